// File: doc/BRIEF.md
# Peripheral Clock Gate Controller

This block decides whether one peripheral clock runs. The clock-gating cell itself is not part of it; the block drives a single enable output that such a cell would use. The enable comes from one of two sources. Software can turn the clock on and off by writing a control register. Alternatively, a hardware request input can be handed control. A control bit chooses which source is in charge.

Two options change when the clock is allowed to stop. A keep-on option holds the clock running whatever the selected source asks for. A turn-off hysteresis option keeps the clock running for a short or long programmable number of cycles after the request to stop. A new request during that window cancels the pending stop, and the enable does not glitch.

A read-only status bit reports the running state. It lags the enable output by a fixed settle latency, which models the time the gating cell needs to settle. Software polls this bit after a change until it matches the state it asked for.

Top module: `periph_clk_gate`

## Requirements
- R1: After reset, every control field reads 0, and `gate_en` and the status bit are both 0.
- R2: The register has the following layout. Bit 0 is the source select, where 1 means software and 0 means the hardware request. Bit 1 is the software enable. Bit 2 turns hysteresis on. Bit 3 picks the delay, where 1 means long and 0 means short. Bit 4 is keep-on. Bit 7 is the read-only status. A write on `wr_en` stores bits 0 to 4. Bits 5 and 6 always read 0, and writes to bits 5 to 7 have no effect. Without a write, the fields hold their value.
- R3: Under software control (bit 0 = 1), `gate_en` follows the software enable in the clock cycle after the write edge.
- R4: Under hardware control (bit 0 = 0), `gate_en` follows `hw_req` one clock edge later. The stored software enable has no effect on `gate_en`.
- R5: With keep-on set, `gate_en` is 1 from the edge after that write, even though the enable bit reads 0, in either control mode.
- R6: The status bit equals `gate_en` delayed by SETTLE clock cycles. A rise and a fall take the same latency.
- R7: With hysteresis off, `gate_en` falls at the first edge at which the request is 0.
- R8: With hysteresis on, `gate_en` falls LOW_DLY edges later than it would without hysteresis when the delay bit is 0. It falls HIGH_DLY edges later when the delay bit is 1.
- R9: A request that returns during the hysteresis window cancels the pending stop, and `gate_en` stays 1 without a gap. A later stop request waits the full delay again.
- R10: Turning on is never delayed. With hysteresis on, `gate_en` still rises at the first edge at which the request is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Register write data |
| hw_req | input | 1 | Hardware clock request, used when the source select is 0 |
| rd_data | output | DATA_W | Register read value, including the status bit |
| gate_en | output | 1 | Enable to the clock-gating cell |
| status | output | 1 | Settled running state; the same value as bit 7 of `rd_data` |

## Verification
The bench sweeps all 64 combinations of the five control fields and the hardware request. In each one it checks the settled enable, the status and the readback. This catches three kinds of fault: a select mux with its polarity inverted, a software enable that leaks through in hardware mode, and a keep-on that applies in only one mode. Edge-to-edge cycle counts pin down the off delay for each hysteresis setting, the on delay with hysteresis enabled, and the status lag. A counter that is off by one, or a design that delays turn-on, therefore shows up as a wrong count. A re-enable in the middle of the window is watched cycle by cycle for a dropout. After it, a fresh stop must wait the full delay again, which exposes a counter that is not reloaded.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

  localparam int unsigned F_SEL   = 0;
  localparam int unsigned F_EN    = 1;
  localparam int unsigned F_HON   = 2;
  localparam int unsigned F_HLONG = 3;
  localparam int unsigned F_KEEP  = 4;
  localparam int unsigned F_STAT  = 7;

  typedef struct packed {
    logic keep_on;
    logic hyst_long;
    logic hyst_on;
    logic sw_en;
    logic sw_sel;
  } pcg_cfg_t;

  // Request seen by the gate: keep-on wins, then the selected source.
  function automatic logic gate_demand(pcg_cfg_t c, logic hw_req);
    return c.keep_on | (c.sw_sel ? c.sw_en : hw_req);
  endfunction

  // Extra edges the gate stays on after the request drops.
  function automatic int unsigned off_delay(logic hyst_on, logic hyst_long,
                                            int unsigned lo, int unsigned hi);
    if (!hyst_on) return 0;
    return hyst_long ? hi : lo;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pcg_regs.sv
module pcg_regs
  import pcg_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              status,
  output pcg_cfg_t          cfg,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_en) begin
      cfg.sw_sel    <= wr_data[F_SEL];
      cfg.sw_en     <= wr_data[F_EN];
      cfg.hyst_on   <= wr_data[F_HON];
      cfg.hyst_long <= wr_data[F_HLONG];
      cfg.keep_on   <= wr_data[F_KEEP];
    end
  end

  always_comb begin
    rd_data          = '0;
    rd_data[F_SEL]   = cfg.sw_sel;
    rd_data[F_EN]    = cfg.sw_en;
    rd_data[F_HON]   = cfg.hyst_on;
    rd_data[F_HLONG] = cfg.hyst_long;
    rd_data[F_KEEP]  = cfg.keep_on;
    rd_data[F_STAT]  = status;
  end

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg));

endmodule

// File: rtl/pcg_hyst.sv
module pcg_hyst
  import pcg_pkg::*;
#(
  parameter int unsigned LOW_DLY  = 4,
  parameter int unsigned HIGH_DLY = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic demand,
  input  logic hyst_on,
  input  logic hyst_long,
  output logic gate_en,
  output logic pend
);

  localparam int unsigned MAX_DLY = max_u(LOW_DLY, HIGH_DLY);
  localparam int unsigned CNT_W   = (MAX_DLY < 2) ? 1 : $clog2(MAX_DLY + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] dly;
  logic             dly_zero;

  assign dly      = CNT_W'(off_delay(hyst_on, hyst_long, LOW_DLY, HIGH_DLY));
  assign dly_zero = (dly == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_en <= 1'b0;
      pend    <= 1'b0;
      cnt     <= '0;
    end else if (demand) begin
      gate_en <= 1'b1;
      pend    <= 1'b0;
      cnt     <= '0;
    end else if (pend) begin
      if (cnt == '0) begin
        gate_en <= 1'b0;
        pend    <= 1'b0;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end else if (gate_en) begin
      if (dly_zero) begin
        gate_en <= 1'b0;
      end else begin
        pend <= 1'b1;
        cnt  <= dly - CNT_W'(1);
      end
    end
  end

  // R10
  on_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    demand |=> gate_en);

  // R9
  no_drop_on_demand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_en) |-> !$past(demand));

  // R7
  off_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !demand && !pend && !hyst_on) |=> !gate_en);

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (int'(cnt) < int'(MAX_DLY)));

endmodule

// File: rtl/pcg_settle.sv
module pcg_settle #(
  parameter int unsigned SETTLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_in,
  output logic status_o
);

  logic [SETTLE-1:0] pipe;

  generate
    for (genvar i = 0; i < SETTLE; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[0] <= 1'b0;
          else        pipe[0] <= gate_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[i] <= 1'b0;
          else        pipe[i] <= pipe[i-1];
        end
      end
    end
  endgenerate

  assign status_o = pipe[SETTLE-1];

endmodule

// File: rtl/periph_clk_gate.sv
module periph_clk_gate
  import pcg_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SETTLE   = 3,
  parameter int unsigned LOW_DLY  = 4,
  parameter int unsigned HIGH_DLY = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hw_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              gate_en,
  output logic              status
);

  pcg_cfg_t cfg;
  logic     demand;
  logic     pend;

  pcg_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .status(status), .cfg(cfg), .rd_data(rd_data)
  );

  assign demand = gate_demand(cfg, hw_req);

  pcg_hyst #(.LOW_DLY(LOW_DLY), .HIGH_DLY(HIGH_DLY)) u_hyst (
    .clk(clk), .rst_n(rst_n), .demand(demand), .hyst_on(cfg.hyst_on),
    .hyst_long(cfg.hyst_long), .gate_en(gate_en), .pend(pend)
  );

  pcg_settle #(.SETTLE(SETTLE)) u_settle (
    .clk(clk), .rst_n(rst_n), .gate_in(gate_en), .status_o(status)
  );

  // R5
  keep_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.keep_on |=> gate_en);

  // R4
  hw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.sw_sel && hw_req) |=> gate_en);

  // R9
  pend_needs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> gate_en);

endmodule

// File: tb/tb_periph_clk_gate.sv
module tb_periph_clk_gate;

  localparam int unsigned DW = 8;
  localparam int unsigned ST = 3;
  localparam int unsigned LO = 4;
  localparam int unsigned HI = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic hw_req = 1'b0;
  logic [DW-1:0] rd_data;
  logic gate_en, status;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  periph_clk_gate #(.DATA_W(DW), .SETTLE(ST), .LOW_DLY(LO), .HIGH_DLY(HI)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .hw_req(hw_req), .rd_data(rd_data), .gate_en(gate_en), .status(status)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Negedges after the last change until the signal leaves level v.
  task automatic edges_until_not(input bit use_status, input logic v, output int n);
    n = 1;
    @(negedge clk);
    while (((use_status ? status : gate_en) == v) && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic logic [DW-1:0] cfgv(bit sel, bit en, bit hon, bit hl, bit kp);
    return DW'({kp, hl, hon, en, sel});
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    int n;
    logic exp_g;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 rd_data", int'(rd_data), 0);
    chk("R1 gate_en", int'(gate_en), 0);
    chk("R1 status", int'(status), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 gate after release", int'(gate_en), 0);

    // R2: upper bits ignored
    wr(8'hFF);
    repeat (20) @(negedge clk);
    chk("R2 readback upper ignored", int'(rd_data), 8'h9F);
    wr(8'hE0);
    repeat (20) @(negedge clk);
    chk("R2 only upper written", int'(rd_data), 0);
    chk("R2 gate off", int'(gate_en), 0);

    // Sweep: R2 R3 R4 R5 R6 steady state
    for (int k = 0; k < 64; k++) begin
      hw_req = k[5];
      wr(cfgv(k[0], k[1], k[2], k[3], k[4]));
      repeat (1 + HI + ST + 4) @(negedge clk);
      exp_g = k[4] | (k[0] ? k[1] : k[5]);
      chk(k[0] ? "R3 sweep gate" : "R4 sweep gate", int'(gate_en), int'(exp_g));
      chk("R6 sweep status", int'(status), int'(exp_g));
      chk("R2 sweep readback", int'(rd_data), int'({exp_g, 2'b00, k[4:0]}));
      if (k[4] && !k[1]) chk("R5 keep-on with enable 0", int'(gate_en), 1);
    end
    hw_req = 1'b0;

    // R3 turn-on latency, R6 status latency
    wr(cfgv(1, 0, 0, 0, 0));
    repeat (20) @(negedge clk);
    wr(cfgv(1, 1, 0, 0, 0));
    edges_until_not(0, 1'b0, n);
    chk("R3 on latency", n, 1);
    edges_until_not(1, 1'b0, n);
    chk("R6 status rise lag", n, ST);
    // R7
    wr(cfgv(1, 0, 0, 0, 0));
    edges_until_not(0, 1'b1, n);
    chk("R7 off latency", n, 1);
    edges_until_not(1, 1'b1, n);
    chk("R6 status fall lag", n, ST);

    // R8 short / long
    wr(cfgv(1, 1, 1, 0, 0));
    repeat (20) @(negedge clk);
    wr(cfgv(1, 0, 1, 0, 0));
    edges_until_not(0, 1'b1, n);
    chk("R8 short delay", n, 1 + LO);
    wr(cfgv(1, 1, 1, 1, 0));
    edges_until_not(0, 1'b0, n);
    chk("R10 on not delayed", n, 1);
    repeat (20) @(negedge clk);
    wr(cfgv(1, 0, 1, 1, 0));
    edges_until_not(0, 1'b1, n);
    chk("R8 long delay", n, 1 + HI);

    // R4 hw timing with hysteresis off, sw enable stored as 1
    wr(cfgv(0, 1, 0, 0, 0));
    repeat (5) @(negedge clk);
    chk("R4 sw enable ignored", int'(gate_en), 0);
    hw_req = 1'b1;
    edges_until_not(0, 1'b0, n);
    chk("R4 hw on latency", n, 1);
    hw_req = 1'b0;
    edges_until_not(0, 1'b1, n);
    chk("R4 hw off latency", n, 1);

    // R9 cancel mid-window
    wr(cfgv(1, 1, 1, 1, 0));
    repeat (20) @(negedge clk);
    wr(cfgv(1, 0, 1, 1, 0));
    repeat (5) @(negedge clk);
    chk("R9 still on in window", int'(gate_en), 1);
    @(negedge clk);
    wr_en = 1'b1; wr_data = cfgv(1, 1, 1, 1, 0);
    begin
      int drops = 0;
      for (int c = 0; c < 25; c++) begin
        @(negedge clk);
        wr_en = 1'b0;
        if (!gate_en) drops++;
      end
      chk("R9 no dropout after cancel", drops, 0);
    end
    wr(cfgv(1, 0, 1, 1, 0));
    edges_until_not(0, 1'b1, n);
    chk("R9 full delay after cancel", n, 1 + HI);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule